// File: doc/BRIEF.md
# Counted-Stop UART Transmitter with FIFO

This block is the transmit half of an asynchronous serial port. The host pushes bytes into a 64-entry byte FIFO. The block turns each byte into a character on a single line output. Each character has a low start bit, then 7 or 8 data bits sent least significant bit first. An optional parity bit or multiprocessor flag bit follows, then one or two high stop bits. The line rests high between characters. Bit timing comes from an oversampling tick supplied from outside, and every bit lasts 16 ticks.

The block can also stop by itself after a programmed number of characters. An 8-bit stop value N allows N+1 characters (1 to 256) once the counted-stop enable is set. After that many characters have fully left the line, the transmitter idles even if the FIFO still holds data. Loading a new stop value, or raising the run input again, rearms the count.

The host can see the FIFO fill level, a sticky flag for writes lost to a full FIFO, and a completion flag.

Top module: `utx_counted_tx`

## Requirements
- R1: The line idles high. A character is one low start bit, then the data bits least significant first, then the optional extra bit, then high stop bits. Each bit holds for exactly 16 asserted `tick` cycles.
- R2: With `fmt_len7`=1 only bits 6..0 of a byte are sent and bit 7 is never placed on the line. With `fmt_len7`=0 all 8 bits are sent.
- R3: With `fmt_par_en`=1 and `fmt_mp_en`=0, one parity bit follows the data. It is computed over the sent data bits only. With `fmt_par_odd`=0 the data bits plus the parity bit hold an even number of ones. With `fmt_par_odd`=1 they hold an odd number.
- R4: With `fmt_mp_en`=1 the extra bit equals `fmt_mp_bit`, whatever `fmt_par_en` is set to.
- R5: `fmt_stop2`=0 gives one stop bit, so a queued character's start bit follows directly after it. `fmt_stop2`=1 gives two stop bits.
- R6: The FIFO holds 64 bytes and sends them in write order. `fill` shows the number of bytes stored.
- R7: A write while `fill` is 64 is discarded. It sets `wr_ovf`, which stays high until reset.
- R8: With `stop_en`=0 and `tx_run`=1 the transmitter sends until the FIFO is empty. With `tx_run`=0 no new character starts.
- R9: With `stop_en`=1 and stop value N, exactly N+1 characters are sent. After that the line stays high and the remaining bytes stay in the FIFO.
- R10: The stop value resets to 0xFF, so 256 characters are allowed after reset.
- R11: `tx_end` is high when no character is being shifted and either the FIFO is empty or the count is exhausted. It is low while a character is on the line or while a sendable byte waits with `tx_run`=1. Its reset value is 1.
- R12: A `stop_wr` pulse, which loads `stop_val`, or a rising edge on `tx_run` reloads the character count and clears `tx_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Byte to queue |
| fmt_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| fmt_par_en | input | 1 | Append a parity bit |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_mp_en | input | 1 | Append the multiprocessor bit (overrides parity) |
| fmt_mp_bit | input | 1 | Value of the multiprocessor bit |
| fmt_stop2 | input | 1 | 1: two stop bits, 0: one |
| tx_run | input | 1 | Transmit enable; a rising edge rearms the count |
| stop_en | input | 1 | Honour the character count |
| stop_wr | input | 1 | Load `stop_val` as the stop value and rearm |
| stop_val | input | 8 | Stop value N (N+1 characters) |
| tick | input | 1 | Oversampling tick, 16 per bit |
| txd | output | 1 | Serial line |
| fill | output | 7 | FIFO occupancy |
| tx_end | output | 1 | Transmission complete |
| wr_ovf | output | 1 | Sticky: a write was dropped |

## Verification
Data patterns are sent with the format bits in several combinations. 7-bit mode is tried with a byte whose top bit is set, which shows whether that bit is really dropped. Parity is checked with bytes holding an even and an odd number of ones, under both polarities. The multiprocessor bit is given a value opposite to the parity the byte would produce, so the two sources cannot be confused.

Back-to-back characters are sampled half a bit after the first stop bit. There the line must be low with one stop bit and high with two. The counted stop is driven with more bytes queued than allowed, at the reset value of 256, at 3 and at 1. This separates off-by-one errors in the count from leaks past the limit. Rearming is tried through both the stop-value write and a run toggle.

// File: rtl/utx_pkg.sv
package utx_pkg;

   localparam int FRAME_W = 12;

   typedef struct packed {
      logic len7;
      logic par_en;
      logic par_odd;
      logic mp_en;
      logic mp_bit;
      logic stop2;
   } utx_fmt_t;

   typedef struct packed {
      logic [3:0]         nbits;
      logic [FRAME_W-1:0] bits;
   } utx_frame_t;

   // Assemble the line bits of one character, bit 0 sent first.
   function automatic utx_frame_t utx_build(input utx_fmt_t f, input logic [7:0] d);
      utx_frame_t r;
      int         pos;
      logic       par;
      r.bits    = '1;
      r.bits[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < 7 || !f.len7) r.bits[1+i] = d[i];
      pos = f.len7 ? 8 : 9;
      par = f.len7 ? ^d[6:0] : ^d;
      if (f.par_odd) par = ~par;
      if (f.mp_en) begin
         r.bits[pos] = f.mp_bit;
         pos++;
      end else if (f.par_en) begin
         r.bits[pos] = par;
         pos++;
      end
      pos     = pos + (f.stop2 ? 2 : 1);
      r.nbits = 4'(pos);
      return r;
   endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic [LW-1:0] level,
   output logic          ovf
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("utx_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("utx_fifo: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cnt;
   logic          full, wr_ok, rd_ok;

   assign full  = (cnt == LW'(DEPTH));
   assign empty = (cnt == '0);
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   assign rd_data = mem[rp];
   assign level   = cnt;

   // R6
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LW'(DEPTH));

   // R6
   level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full && !rd_en) |=> (cnt == $past(cnt) + 1'b1));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import utx_pkg::*;
#(
   parameter int OSR  = 16,
   localparam int TW  = $clog2(OSR)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       load,
   input  utx_frame_t frame,
   output logic       busy,
   output logic       done,
   output logic       txd
);

   generate
      if (OSR < 2) begin : g_bad_osr
         $error("utx_shifter: OSR must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] shreg;
   logic [3:0]         bits_left;
   logic [TW-1:0]      tcnt;
   logic               bit_end;

   assign bit_end = busy && tick && (tcnt == TW'(OSR - 1));
   assign done    = bit_end && (bits_left == 4'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '1;
         bits_left <= '0;
         tcnt      <= '0;
         busy      <= 1'b0;
      end else if (load && !busy) begin
         shreg     <= frame.bits;
         bits_left <= frame.nbits;
         tcnt      <= '0;
         busy      <= 1'b1;
      end else if (busy && tick) begin
         if (bit_end) begin
            tcnt      <= '0;
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == 4'd1) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign txd = busy ? shreg[0] : 1'b1;

   // R1
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));

   // R1
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/utx_counted_tx.sv
module utx_counted_tx
   import utx_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int OSR   = 16,
   parameter int CW    = 8,
   localparam int LW   = $clog2(DEPTH + 1),
   localparam int RW   = CW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          fmt_len7,
   input  logic          fmt_par_en,
   input  logic          fmt_par_odd,
   input  logic          fmt_mp_en,
   input  logic          fmt_mp_bit,
   input  logic          fmt_stop2,
   input  logic          tx_run,
   input  logic          stop_en,
   input  logic          stop_wr,
   input  logic [CW-1:0] stop_val,
   input  logic          tick,
   output logic          txd,
   output logic [LW-1:0] fill,
   output logic          tx_end,
   output logic          wr_ovf
);

   generate
      if (CW < 1 || CW > 16) begin : g_bad_cw
         $error("utx_counted_tx: CW out of range");
      end
   endgenerate

   utx_fmt_t    fmt;
   utx_frame_t  frame;
   logic [7:0]  head;
   logic        empty, sh_busy, sh_done, start;
   logic        run_q, reload, limit;
   logic [CW-1:0] stop_reg;
   logic [RW-1:0] remain;

   assign fmt   = '{len7: fmt_len7, par_en: fmt_par_en, par_odd: fmt_par_odd,
                    mp_en: fmt_mp_en, mp_bit: fmt_mp_bit, stop2: fmt_stop2};
   assign frame = utx_build(fmt, head);

   assign reload = stop_wr || (tx_run && !run_q);
   assign limit  = stop_en && (remain == '0);
   assign start  = tx_run && !sh_busy && !empty && !limit;

   utx_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (start),
      .rd_data (head),
      .empty   (empty),
      .level   (fill),
      .ovf     (wr_ovf)
   );

   utx_shifter #(.OSR(OSR)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (start),
      .frame (frame),
      .busy  (sh_busy),
      .done  (sh_done),
      .txd   (txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         stop_reg <= '1;
         remain   <= RW'({CW{1'b1}}) + 1'b1;
         tx_end   <= 1'b1;
      end else begin
         run_q <= tx_run;
         if (stop_wr) stop_reg <= stop_val;
         if (reload)
            remain <= RW'(stop_wr ? stop_val : stop_reg) + 1'b1;
         else if (sh_done && remain != '0)
            remain <= remain - 1'b1;
         tx_end <= reload ? 1'b0 : (!sh_busy && (empty || limit));
      end
   end

   // R9
   remain_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reload) |-> (remain <= $past(remain)));

   // R9
   limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (limit && !sh_busy) |=> !sh_busy);

   // R11
   end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end |-> txd);

endmodule

// File: tb/utx_counted_tx_test.sv
module utx_counted_tx_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic fmt_len7 = 1'b0, fmt_par_en = 1'b0, fmt_par_odd = 1'b0;
   logic fmt_mp_en = 1'b0, fmt_mp_bit = 1'b0, fmt_stop2 = 1'b0;
   logic tx_run = 1'b0, stop_en = 1'b0, stop_wr = 1'b0;
   logic [7:0] stop_val = 8'h00;
   logic tick = 1'b0;
   logic txd, tx_end, wr_ovf;
   logic [6:0] fill;

   int n_cmp = 0;
   int n_bad = 0;
   int tick_div = 2;
   int tdc = 0;

   utx_counted_tx uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fmt_len7(fmt_len7), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
      .fmt_mp_en(fmt_mp_en), .fmt_mp_bit(fmt_mp_bit), .fmt_stop2(fmt_stop2),
      .tx_run(tx_run), .stop_en(stop_en), .stop_wr(stop_wr), .stop_val(stop_val),
      .tick(tick), .txd(txd), .fill(fill), .tx_end(tx_end), .wr_ovf(wr_ovf)
   );

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (tdc >= tick_div - 1) begin
         tick <= 1'b1;
         tdc = 0;
      end else begin
         tick <= 1'b0;
         tdc = tdc + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
      #1;
   endtask

   task automatic put(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic load_stop(input logic [7:0] v);
      @(negedge clk);
      stop_wr  = 1'b1;
      stop_val = v;
      @(negedge clk);
      stop_wr  = 1'b0;
   endtask

   // Decodes one character from the line; with aligned set the caller is
   // already at the middle of the start bit.
   task automatic rx_frame(input int nd, input bit extra, input int nst, input bit aligned,
                           output logic [7:0] d, output logic x, output bit ok);
      ok = 1'b1;
      d  = 8'h00;
      x  = 1'b0;
      if (!aligned) begin
         @(negedge clk);
         while (txd !== 1'b0) @(negedge clk);
         wait_ticks(8);
         if (txd !== 1'b0) ok = 1'b0;
      end
      for (int i = 0; i < nd; i++) begin
         wait_ticks(16);
         d[i] = txd;
      end
      if (extra) begin
         wait_ticks(16);
         x = txd;
      end
      for (int s = 0; s < nst; s++) begin
         wait_ticks(16);
         if (txd !== 1'b1) ok = 1'b0;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 idle line after reset", txd, 1);
      chk("R6 fill after reset", fill, 0);
      chk("R11 tx_end after reset", tx_end, 1);
      chk("R7 wr_ovf after reset", wr_ovf, 0);
   endtask

   // R10: default stop value allows 256 characters.
   task automatic t_default_count;
      logic [7:0] d;
      logic x;
      bit ok;
      int errs;
      errs     = 0;
      tick_div = 1;
      stop_en  = 1'b1;
      tx_run   = 1'b1;
      fork
         begin
            for (int k = 0; k < 257; k++) begin
               @(negedge clk);
               while (fill >= 7'd64) @(negedge clk);
               put(k[7:0]);
            end
         end
         begin
            for (int k = 0; k < 256; k++) begin
               rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
               if (d !== k[7:0] || !ok) errs++;
            end
         end
      join
      chk("R10 256 characters intact", errs, 0);
      repeat (400) @(negedge clk);
      chk("R10 halted with one byte left", fill, 1);
      chk("R10 tx_end at limit", tx_end, 1);
      stop_en = 1'b0;
      rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
      chk("R8 leftover sent once count ignored", d, 8'h00);
      repeat (40) @(negedge clk);
      chk("R8 fifo drained", fill, 0);
   endtask

   task automatic t_basic;
      logic [7:0] d;
      logic x;
      bit ok;
      tick_div = 2;
      put(8'hA5);
      put(8'h3C);
      chk("R11 tx_end low while sending", tx_end, 0);
      rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
      chk("R1 first character", d, 8'hA5);
      chk("R1 start/stop levels", ok, 1);
      wait_ticks(16);
      chk("R5 one stop bit, next start follows", txd, 0);
      rx_frame(8, 1'b0, 1, 1'b1, d, x, ok);
      chk("R6 second character in order", d, 8'h3C);
      repeat (60) @(negedge clk);
      chk("R11 tx_end after drain", tx_end, 1);
      chk("R8 fifo empty", fill, 0);
   endtask

   task automatic t_len7_parity;
      logic [7:0] d;
      logic x;
      bit ok;
      fmt_len7   = 1'b1;
      fmt_par_en = 1'b1;
      fmt_par_odd = 1'b0;
      fmt_stop2  = 1'b1;
      put(8'hD3);
      put(8'h07);
      rx_frame(7, 1'b1, 2, 1'b0, d, x, ok);
      chk("R2 7-bit data drops bit 7", d, 8'h53);
      chk("R3 even parity, four ones", x, 0);
      chk("R5 two stop bits high", ok, 1);
      rx_frame(7, 1'b1, 2, 1'b0, d, x, ok);
      chk("R3 even parity, three ones", x, 1);
      repeat (80) @(negedge clk);
      fmt_par_odd = 1'b1;
      put(8'h07);
      rx_frame(7, 1'b1, 2, 1'b0, d, x, ok);
      chk("R3 odd parity, three ones", x, 0);
      chk("R2 7-bit value", d, 8'h07);
      repeat (80) @(negedge clk);
      fmt_len7   = 1'b0;
      fmt_stop2  = 1'b0;
   endtask

   task automatic t_mp;
      logic [7:0] d;
      logic x;
      bit ok;
      fmt_par_en  = 1'b1;
      fmt_par_odd = 1'b0;
      fmt_mp_en   = 1'b1;
      fmt_mp_bit  = 1'b1;
      put(8'h00);
      rx_frame(8, 1'b1, 1, 1'b0, d, x, ok);
      chk("R4 mp bit 1 over parity 0", x, 1);
      repeat (60) @(negedge clk);
      fmt_mp_bit = 1'b0;
      put(8'h01);
      rx_frame(8, 1'b1, 1, 1'b0, d, x, ok);
      chk("R4 mp bit 0 over parity 1", x, 0);
      chk("R4 data intact", d, 8'h01);
      repeat (60) @(negedge clk);
      fmt_mp_en  = 1'b0;
      fmt_par_en = 1'b0;
   endtask

   task automatic t_count;
      logic [7:0] d;
      logic x;
      bit ok;
      int lows;
      stop_en = 1'b1;
      load_stop(8'd2);
      for (int k = 0; k < 5; k++) put(8'h10 + k[7:0]);
      for (int k = 0; k < 3; k++) begin
         rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
         chk("R9 counted character", d, 8'h10 + k[7:0]);
      end
      lows = 0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
      chk("R9 line held high after count", lows, 0);
      chk("R9 bytes kept in fifo", fill, 2);
      chk("R11 tx_end at count", tx_end, 1);
      load_stop(8'd0);
      @(negedge clk);
      chk("R12 stop_wr clears tx_end", tx_end, 0);
      rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
      chk("R12 one character after reload", d, 8'h13);
      repeat (800) @(negedge clk);
      chk("R9 one byte left", fill, 1);
      chk("R11 tx_end after single", tx_end, 1);
      tx_run = 1'b0;
      repeat (3) @(negedge clk);
      tx_run = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R12 run edge clears tx_end", tx_end, 0);
      rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
      chk("R12 run edge rearms count", d, 8'h14);
      repeat (200) @(negedge clk);
      chk("R9 fifo empty at end", fill, 0);
      stop_en = 1'b0;
   endtask

   task automatic t_ovf;
      logic [7:0] d;
      logic x;
      bit ok;
      tick_div = 1;
      tx_run   = 1'b0;
      for (int k = 0; k < 64; k++) put(k[7:0]);
      @(negedge clk);
      chk("R6 fifo holds 64", fill, 64);
      chk("R7 no overflow at 64", wr_ovf, 0);
      chk("R8 nothing sent with run low", txd, 1);
      put(8'hEE);
      @(negedge clk);
      chk("R7 write to full dropped", fill, 64);
      chk("R7 overflow flagged", wr_ovf, 1);
      tx_run = 1'b1;
      rx_frame(8, 1'b0, 1, 1'b0, d, x, ok);
      chk("R6 oldest byte first", d, 8'h00);
      while (!(fill == 7'd0 && tx_end)) @(negedge clk);
      chk("R7 overflow stays set", wr_ovf, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default_count();
      t_basic();
      t_len7_parity();
      t_mp();
      t_count();
      t_ovf();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule